// File: doc/BRIEF.md
# Debug Halt and Monitor Controller

This block decides how a small processor core reacts to a debug event. Three sources raise events: a breakpoint instruction, an address-comparator match and an external halt request. When halting debug is enabled, an event or a software halt command stops the core. The block then holds the run enable low, freezes the system tick timer, and can release the core for exactly one retired instruction at a time. While such a step is in flight, interrupts can be masked.

When halting debug is off but monitor debug is on, a breakpoint or comparator event becomes a one-cycle request for the debug-monitor exception, which carries exception number 12. The tick timer keeps running in this mode. If the core is already executing at a priority equal to or above the monitor, the event is dropped and a sticky flag records the loss. Monitor stepping raises a monitor request after every retired instruction, but only while the current level lets the monitor preempt.

Software drives the block through a 7-bit control word written with a strobe. It reads back a 4-bit status word.

Top module: `dbg_ctl`

## Requirements
- R1: After reset the core runs (`core_run`=1, `tick_en`=1), `irq_mask`=0, `mon_req`=0 and `stat_rdata`=0.
- R2: A control write with bit0 (halt enable)=1 and bit1 (halt)=1 makes `core_run`=0, `tick_en`=0 and `stat_rdata[0]` (halted)=1 from the next cycle on. The same write with bit0=0 is ignored and the core keeps running.
- R3: While the halt enable is set, a pulse on `ev_bkpt`, `ev_cmp` or `ev_ext` halts the core from the next cycle. The halted state then persists without further writes.
- R4: In the halted state, a write with bit0=1, bit1=1 and bit2 (step)=1 sets `core_run`=1 and `stat_rdata[1]` (stepping)=1, with `tick_en` still 0. The first `retire` pulse returns the core to the halted state on the next cycle.
- R5: `irq_mask` is 1 only while stepping with control bit3 (step mask) set.
- R6: Writing bit1=0 while halted or stepping, or clearing bit0, resumes execution from the next cycle. `stat_rdata[3]` reflects the stored halt enable.
- R7: With halt enable clear and bit4 (monitor enable)=1, an `ev_bkpt` or `ev_cmp` pulse gives `mon_req`=1 for one cycle on the next cycle, with `mon_exc_num`=12; otherwise `mon_exc_num`=0. The tick keeps running and `ev_ext` is ignored.
- R8: A monitor event is dropped when `cur_active`=1 and `cur_prio` <= `mon_prio` (a lower number is a higher priority). A dropped event raises no request and sets sticky `stat_rdata[2]`, which only a write with bit6 (clear drop)=1 clears.
- R9: When both enables are set, events halt the core and no monitor request is raised.
- R10: With monitor enable and bit5 (monitor step) set and halt enable clear, each `retire` pulse at an unblocked level raises `mon_req` on the next cycle. A blocked retire raises nothing and sets no drop flag.
- R11: With both enables clear, events and retire pulses change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word (bit0 halt enable, bit1 halt, bit2 step, bit3 step mask, bit4 monitor enable, bit5 monitor step, bit6 clear drop) |
| ev_bkpt | input | 1 | Breakpoint instruction event pulse |
| ev_cmp | input | 1 | Address comparator match pulse |
| ev_ext | input | 1 | External halt request pulse |
| retire | input | 1 | Instruction retired pulse from the core |
| cur_active | input | 1 | Core is executing an exception handler |
| cur_prio | input | 8 | Priority of the current execution level |
| mon_prio | input | 8 | Priority of the debug-monitor exception |
| core_run | output | 1 | Execution enable to the core |
| tick_en | output | 1 | System tick counter enable |
| irq_mask | output | 1 | Mask external interrupts |
| mon_req | output | 1 | Debug-monitor exception request pulse |
| mon_exc_num | output | 9 | Exception number carried by the request |
| stat_rdata | output | 4 | Status: bit0 halted, bit1 stepping, bit2 dropped, bit3 halt enable |

## Verification
The assertions assume that `retire` pulses arrive only while `core_run` is high. They also assume that a halted core keeps its state unless a control write comes in. The stimulus uses the bench's own model of `core_run` and only drives `retire` in cycles where that model says the core runs. The stimulus randomises writes, events and priorities, including priorities equal to the monitor's, so that both the drop path and the request path are reached.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int PRIO_W = 8;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STEP = 2'd2
  } run_st_t;

  typedef struct packed {
    logic clr_drop;
    logic mon_step;
    logic mon_en;
    logic step_mask;
    logic step;
    logic halt;
    logic halt_en;
  } ctl_word_t;

  // lower number wins: monitor cannot preempt equal or higher levels
  function automatic logic prio_blocks(input logic act,
                                       input logic [PRIO_W-1:0] cur,
                                       input logic [PRIO_W-1:0] mon);
    return act && (cur <= mon);
  endfunction
endpackage

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
  import dbg_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  logic    w_halt_en,
  input  logic    w_halt,
  input  logic    w_step,
  input  logic    w_mask,
  input  logic    ev_any,
  input  logic    retire,
  output run_st_t st,
  output logic    halt_en_q,
  output logic    mask_q
);
  logic    en_eff;
  logic    halt_cmd;
  logic    resume_cmd;
  logic    step_cmd;
  run_st_t st_nxt;

  assign en_eff     = wr ? w_halt_en : halt_en_q;
  assign halt_cmd   = wr && w_halt;
  assign resume_cmd = wr && !w_halt;
  assign step_cmd   = wr && w_halt && w_step;

  always_comb begin
    st_nxt = st;
    if (!en_eff) begin
      st_nxt = ST_RUN;
    end else begin
      unique case (st)
        ST_RUN:  if (halt_cmd || ev_any) st_nxt = ST_HALT;
        ST_HALT: if (resume_cmd) st_nxt = ST_RUN;
                 else if (step_cmd) st_nxt = ST_STEP;
        ST_STEP: if (resume_cmd) st_nxt = ST_RUN;
                 else if (retire || ev_any) st_nxt = ST_HALT;
        default: st_nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_RUN;
      halt_en_q <= 1'b0;
      mask_q    <= 1'b0;
    end else begin
      st <= st_nxt;
      if (wr) begin
        halt_en_q <= w_halt_en;
        mask_q    <= w_mask;
      end
    end
  end

  AST_HALT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN) |-> halt_en_q); // R2

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT && !wr) |=> (st == ST_HALT)); // R3

  AST_STEP_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STEP && retire && !wr) |=> (st == ST_HALT)); // R4
endmodule

// File: rtl/dbg_mon_gate.sv
module dbg_mon_gate
  import dbg_ctl_pkg::*;
#(
  parameter int EXC_NUM = 12,
  parameter int EXC_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              w_mon_en,
  input  logic              w_mon_step,
  input  logic              w_clr,
  input  logic              halt_en_q,
  input  logic              ev_sw,
  input  logic              retire,
  input  logic              cur_active,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [PRIO_W-1:0] mon_prio,
  output logic              mon_req,
  output logic [EXC_W-1:0]  mon_exc_num,
  output logic              drop_q,
  output logic              mon_blocked,
  output logic              mon_fire
);
  logic mon_en_q;
  logic mon_step_q;
  logic step_fire;

  assign mon_blocked = prio_blocks(cur_active, cur_prio, mon_prio);
  assign mon_fire    = !halt_en_q && mon_en_q && ev_sw;
  assign step_fire   = !halt_en_q && mon_en_q && mon_step_q && retire;
  assign mon_exc_num = mon_req ? EXC_W'(EXC_NUM) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en_q   <= 1'b0;
      mon_step_q <= 1'b0;
      mon_req    <= 1'b0;
      drop_q     <= 1'b0;
    end else begin
      if (wr) begin
        mon_en_q   <= w_mon_en;
        mon_step_q <= w_mon_step;
      end
      mon_req <= (mon_fire || step_fire) && !mon_blocked;
      if (mon_fire && mon_blocked)  drop_q <= 1'b1;
      else if (wr && w_clr)         drop_q <= 1'b0;
    end
  end

  AST_DROP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_fire && mon_blocked) |=> (!mon_req && drop_q)); // R8

  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && !(wr && w_clr)) |=> drop_q); // R8

  AST_FIRE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_fire && !mon_blocked) |=> mon_req); // R7
endmodule

// File: rtl/dbg_ctl.sv
module dbg_ctl
  import dbg_ctl_pkg::*;
#(
  parameter int EXC_NUM = 12,
  parameter int EXC_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [6:0]        ctl_wdata,
  input  logic              ev_bkpt,
  input  logic              ev_cmp,
  input  logic              ev_ext,
  input  logic              retire,
  input  logic              cur_active,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [PRIO_W-1:0] mon_prio,
  output logic              core_run,
  output logic              tick_en,
  output logic              irq_mask,
  output logic              mon_req,
  output logic [EXC_W-1:0]  mon_exc_num,
  output logic [3:0]        stat_rdata
);
  ctl_word_t cw;
  run_st_t   st;
  logic      halt_en_q;
  logic      mask_q;
  logic      drop_q;
  logic      ev_any;
  logic      ev_sw;
  logic      halted;
  logic      stepping;
  logic      mon_blocked;
  logic      mon_fire;

  assign cw       = ctl_word_t'(ctl_wdata);
  assign ev_sw    = ev_bkpt || ev_cmp;
  assign ev_any   = ev_sw || ev_ext;
  assign halted   = (st == ST_HALT);
  assign stepping = (st == ST_STEP);

  dbg_halt_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctl_wr),
    .w_halt_en (cw.halt_en),
    .w_halt    (cw.halt),
    .w_step    (cw.step),
    .w_mask    (cw.step_mask),
    .ev_any    (ev_any),
    .retire    (retire),
    .st        (st),
    .halt_en_q (halt_en_q),
    .mask_q    (mask_q)
  );

  dbg_mon_gate #(.EXC_NUM(EXC_NUM), .EXC_W(EXC_W)) u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (ctl_wr),
    .w_mon_en    (cw.mon_en),
    .w_mon_step  (cw.mon_step),
    .w_clr       (cw.clr_drop),
    .halt_en_q   (halt_en_q),
    .ev_sw       (ev_sw),
    .retire      (retire),
    .cur_active  (cur_active),
    .cur_prio    (cur_prio),
    .mon_prio    (mon_prio),
    .mon_req     (mon_req),
    .mon_exc_num (mon_exc_num),
    .drop_q      (drop_q),
    .mon_blocked (mon_blocked),
    .mon_fire    (mon_fire)
  );

  assign core_run   = !halted;
  assign tick_en    = !halted && !stepping;
  assign irq_mask   = stepping && mask_q;
  assign stat_rdata = {halt_en_q, drop_q, stepping, halted};

  AST_MON_ONLY_UNHALTED: assert property (@(posedge clk) disable iff (!rst_n)
    mon_req |-> $past(!halt_en_q)); // R9

  AST_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |-> !tick_en); // R2
endmodule

// File: tb/test_dbg_ctl.sv
module test_dbg_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic       ev_bkpt = 1'b0, ev_cmp = 1'b0, ev_ext = 1'b0, retire = 1'b0;
  logic       cur_active = 1'b0;
  logic [7:0] cur_prio = '0, mon_prio = '0;
  logic       core_run, tick_en, irq_mask, mon_req;
  logic [8:0] mon_exc_num;
  logic [3:0] stat_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit m_halt, m_step, m_en, m_mask, m_mon, m_mstep, m_drop, m_req;

  localparam logic [6:0] B_EN = 7'h01, B_HALT = 7'h02, B_STEP = 7'h04,
                         B_MASK = 7'h08, B_MON = 7'h10, B_MSTEP = 7'h20,
                         B_CLR = 7'h40;

  always #4 clk = ~clk;

  dbg_ctl i_dbg_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ev_bkpt(ev_bkpt), .ev_cmp(ev_cmp), .ev_ext(ev_ext), .retire(retire),
    .cur_active(cur_active), .cur_prio(cur_prio), .mon_prio(mon_prio),
    .core_run(core_run), .tick_en(tick_en), .irq_mask(irq_mask),
    .mon_req(mon_req), .mon_exc_num(mon_exc_num), .stat_rdata(stat_rdata)
  );

  function automatic logic [16:0] expected();
    logic [8:0] num = m_req ? 9'd12 : 9'd0;
    return {!m_halt, !(m_halt || m_step), m_step && m_mask, m_req, num,
            m_en, m_drop, m_step, m_halt};
  endfunction

  task automatic compare(input string tag);
    logic [16:0] got = {core_run, tick_en, irq_mask, mon_req, mon_exc_num, stat_rdata};
    logic [16:0] exp = expected();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit blocked();
    return cur_active && (cur_prio <= mon_prio);
  endfunction

  // advance the model by one clock from the driven inputs
  task automatic model_step();
    bit ev = ev_bkpt | ev_cmp | ev_ext;
    bit en_new = ctl_wr ? ctl_wdata[0] : m_en;
    bit fire = !m_en && m_mon && (ev_bkpt | ev_cmp);
    bit sfire = !m_en && m_mon && m_mstep && retire;
    bit h = m_halt, s = m_step;
    if (!en_new) begin h = 0; s = 0; end
    else if (m_halt) begin
      if (ctl_wr && !ctl_wdata[1]) h = 0;
      else if (ctl_wr && ctl_wdata[2]) begin h = 0; s = 1; end
    end else if (m_step) begin
      if (ctl_wr && !ctl_wdata[1]) s = 0;
      else if (retire || ev) begin s = 0; h = 1; end
    end else if ((ctl_wr && ctl_wdata[1]) || ev) h = 1;
    m_req = (fire || sfire) && !blocked();
    if (fire && blocked()) m_drop = 1;
    else if (ctl_wr && ctl_wdata[6]) m_drop = 0;
    if (ctl_wr) begin
      m_mask = ctl_wdata[3]; m_mon = ctl_wdata[4]; m_mstep = ctl_wdata[5];
    end
    m_en = en_new; m_halt = h; m_step = s;
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    #1;
    compare(tag);
    ctl_wr = 0; ev_bkpt = 0; ev_cmp = 0; ev_ext = 0; retire = 0;
  endtask

  task automatic wr(input logic [6:0] d, input string tag);
    ctl_wr = 1; ctl_wdata = d; cyc(tag);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 compare("R1 reset");
    mon_prio = 8'd40;

    // R11: nothing enabled
    ev_bkpt = 1; cyc("R11 bkpt ignored");
    ev_ext = 1; ev_cmp = 1; retire = 1; cyc("R11 events ignored");
    cyc("R11 quiet");
    // R2 halt without enable ignored, then with enable
    wr(B_HALT, "R2 halt without enable");
    wr(B_EN | B_HALT, "R2 halt with enable");
    repeat (3) cyc("R3 halt persists");
    // R4/R5 step with mask
    wr(B_EN | B_HALT | B_STEP | B_MASK, "R4 step begins");
    cyc("R5 mask during step");
    retire = 1; cyc("R4 retire rehalts");
    cyc("R4 stays halted");
    wr(B_EN | B_HALT | B_STEP, "R5 step unmasked");
    retire = 1; cyc("R4 retire rehalts 2");
    // R6 resume
    wr(B_EN, "R6 resume");
    // R3 each event
    ev_ext = 1; cyc("R3 ext halts");
    wr(B_EN, "R6 resume 2");
    ev_cmp = 1; cyc("R3 cmp halts");
    wr(B_EN | B_HALT | B_STEP, "R4 step");
    wr(7'h00, "R6 enable cleared resumes");
    // R9 precedence
    wr(B_EN | B_MON, "R9 both enabled");
    ev_bkpt = 1; cyc("R9 bkpt halts, no request");
    cyc("R9 after");
    wr(B_MON, "R7 monitor only");
    // R7 monitor
    ev_bkpt = 1; cyc("R7 bkpt event");
    cyc("R7 request dropped after one cycle");
    ev_ext = 1; cyc("R7 ext ignored");
    ev_cmp = 1; cyc("R7 cmp event");
    // R8 drop at equal and higher priority
    cur_active = 1; cur_prio = 8'd40; ev_bkpt = 1; cyc("R8 equal prio drops");
    cyc("R8 sticky");
    cur_prio = 8'd41; ev_bkpt = 1; cyc("R8 lower prio preempts");
    cur_prio = 8'd3; ev_cmp = 1; cyc("R8 higher prio drops");
    wr(B_MON | B_CLR, "R8 clear drop");
    cur_active = 0; cur_prio = 8'd0; ev_bkpt = 1; cyc("R8 thread level not blocked");
    // R10 monitor stepping
    wr(B_MON | B_MSTEP, "R10 monitor step on");
    retire = 1; cyc("R10 retire requests");
    cur_active = 1; cur_prio = 8'd40; retire = 1; cyc("R10 blocked retire silent");
    cyc("R10 after blocked");
    cur_active = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      ctl_wr = (r[3:0] == 0);
      ctl_wdata = 7'($urandom);
      if (r[5:4] == 0) ctl_wdata[0] = 0;
      ev_bkpt = (r[8:6] == 0);
      ev_cmp = (r[11:9] == 0);
      ev_ext = (r[14:12] == 0);
      retire = !m_halt && r[15];
      cur_active = r[16];
      cur_prio = (r[18:17] == 0) ? mon_prio : 8'(r[31:24]);
      cyc("R3/R4/R6/R7/R8/R10 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule